// File: doc/BRIEF.md
# Multi-Mode Capture Trigger

This block watches a sampled bus of digital channels and raises one trigger flag for a capture engine. Software picks a mode, a base channel, a window width and a required value. The unit then waits for the condition and latches the flag. The three modes are:

- a single-channel transition,
- a short pattern that is checked on every clock,
- a wider pattern that is checked only on its own slower evaluation cadence.

The configuration is taken in on an arm pulse. If the configuration is out of range, the arm is refused and the unit stays idle. Once the flag is set, it holds until the next arm.

Top module: `pattern_trigger`

## Requirements
- R1: After reset, `trig_o` and `armed_o` are both 0.
- R2: With mode 0 (transition) and `cfg_value[0]`=1, `trig_o` rises one clock after the first sample in which channel `cfg_base` is 1 while the previous sample was 0. The first comparison uses the second sample after the arm edge.
- R3: With mode 0 and `cfg_value[0]`=0, the unit fires on a 1-to-0 transition of channel `cfg_base`. A rising transition does not fire it.
- R4: With mode 1 (short pattern), `trig_o` rises one clock after a sample in which channel `cfg_base+i` equals `cfg_value[i]` for every i below `cfg_width`. Bit 0 of the value belongs to the base channel.
- R5: With mode 2 (wide pattern), the window is compared only on every `EVAL_DIV`-th clock edge counted from the arm edge. A match that is gone by the next such edge is missed.
- R6: In mode 2, `trig_o` rises two clocks after the evaluation edge that samples a match.
- R7: An arm is refused, leaving `armed_o` and `trig_o` at 0 so that nothing fires, if any of the following holds: the mode is 3; mode 1 has a width outside 1..`FAST_MAX`, or base+width exceeds `NUM_CH`; mode 2 has a width outside 1..`WIDE_MAX`, or base+width exceeds `WIDE_CH`; mode 0 has a base of `NUM_CH` or more.
- R8: Once set, `trig_o` stays 1 whatever the channels do, until an arm pulse. The arm pulse clears it on the same edge.
- R9: `armed_o` is 1 from an accepted arm until the trigger fires. While it is 0, matches have no effect.
- R10: Channels outside the configured window have no effect on the match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_i | input | NUM_CH | Sampled channel bus |
| cfg_mode | input | 2 | 0 transition, 1 short pattern, 2 wide pattern, 3 reserved |
| cfg_base | input | BASE_W | Lowest channel of the window |
| cfg_width | input | WID_W | Number of channels in the window |
| cfg_value | input | WIDE_MAX | Required state per channel; in mode 0 bit 0 selects the edge polarity |
| arm_i | input | 1 | Pulse that loads the configuration and re-arms the unit |
| trig_o | output | 1 | Latched trigger flag |
| armed_o | output | 1 | Unit is waiting for its condition |

## Verification
The hardest case to reach is a wide-pattern match that is present on the bus but falls between evaluation edges, so it must be missed. The evaluation counter restarts at every arm. This lets the stimulus place a one-clock pattern exactly on a non-evaluation edge, counted from the arm edge. A second arm then holds the pattern across an evaluation edge, so the two-clock latency can be measured edge by edge.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic [1:0] {
    MODE_EDGE = 2'd0,
    MODE_FAST = 2'd1,
    MODE_WIDE = 2'd2,
    MODE_RSVD = 2'd3
  } trig_mode_e;
endpackage

// File: rtl/trig_cfg_check.sv
module trig_cfg_check
  import trig_pkg::*;
#(
  parameter int NUM_CH   = 24,
  parameter int FAST_MAX = 5,
  parameter int WIDE_MAX = 16,
  parameter int WIDE_CH  = 16,
  parameter int BASE_W   = 5,
  parameter int WID_W    = 5
) (
  input  trig_mode_e        mode_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [WID_W-1:0]  width_i,
  output logic              ok_o
);
  int span;
  always_comb begin
    span = int'(base_i) + int'(width_i);
    unique case (mode_i)
      MODE_EDGE: ok_o = int'(base_i) < NUM_CH;
      MODE_FAST: ok_o = (width_i != '0) && (int'(width_i) <= FAST_MAX) && (span <= NUM_CH);
      MODE_WIDE: ok_o = (width_i != '0) && (int'(width_i) <= WIDE_MAX) && (span <= WIDE_CH);
      default:   ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/trig_window.sv
module trig_window #(
  parameter int NUM_CH = 24,
  parameter int PW     = 16,
  parameter int BASE_W = 5,
  parameter int WID_W  = 5
) (
  input  logic [NUM_CH-1:0] chan_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [WID_W-1:0]  width_i,
  input  logic [PW-1:0]     value_i,
  output logic              lsb_o,
  output logic              match_o
);
  logic [NUM_CH-1:0] shifted;
  logic [PW-1:0]     mask;

  assign shifted = chan_i >> base_i;
  assign lsb_o   = shifted[0];

  for (genvar i = 0; i < PW; i++) begin : g_mask
    assign mask[i] = (i < int'(width_i));
  end

  assign match_o = (((shifted[PW-1:0] ^ value_i) & mask) == '0);
endmodule

// File: rtl/trig_wide_stage.sv
module trig_wide_stage #(
  parameter int EVAL_DIV = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  input  logic enable_i,
  input  logic match_i,
  output logic hit_o
);
  localparam int CW = (EVAL_DIV > 1) ? $clog2(EVAL_DIV) : 1;
  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = (int'(cnt) == EVAL_DIV - 1);

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      cnt   <= '0;
      hit_o <= 1'b0;
    end else begin
      cnt   <= tick ? '0 : cnt + 1'b1;
      hit_o <= tick && enable_i && match_i;
    end
  end

  a_r5_eval_on_tick: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> $past(tick));
endmodule

// File: rtl/pattern_trigger.sv
module pattern_trigger
  import trig_pkg::*;
#(
  parameter int NUM_CH   = 24,
  parameter int FAST_MAX = 5,
  parameter int WIDE_MAX = 16,
  parameter int WIDE_CH  = 16,
  parameter int EVAL_DIV = 3,
  parameter int BASE_W   = $clog2(NUM_CH),
  parameter int WID_W    = $clog2(WIDE_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_CH-1:0]   chan_i,
  input  logic [1:0]          cfg_mode,
  input  logic [BASE_W-1:0]   cfg_base,
  input  logic [WID_W-1:0]    cfg_width,
  input  logic [WIDE_MAX-1:0] cfg_value,
  input  logic                arm_i,
  output logic                trig_o,
  output logic                armed_o
);
  trig_mode_e          mode_q;
  logic [BASE_W-1:0]   base_q;
  logic [WID_W-1:0]    width_q;
  logic [WIDE_MAX-1:0] value_q;
  logic                cfg_ok, cur_bit, win_match, wide_hit;
  logic                prev_q, prev_ok, edge_hit, fire;

  trig_cfg_check #(
    .NUM_CH(NUM_CH), .FAST_MAX(FAST_MAX), .WIDE_MAX(WIDE_MAX),
    .WIDE_CH(WIDE_CH), .BASE_W(BASE_W), .WID_W(WID_W)
  ) u_check (
    .mode_i(trig_mode_e'(cfg_mode)), .base_i(cfg_base),
    .width_i(cfg_width), .ok_o(cfg_ok)
  );

  trig_window #(
    .NUM_CH(NUM_CH), .PW(WIDE_MAX), .BASE_W(BASE_W), .WID_W(WID_W)
  ) u_win (
    .chan_i(chan_i), .base_i(base_q), .width_i(width_q),
    .value_i(value_q), .lsb_o(cur_bit), .match_o(win_match)
  );

  trig_wide_stage #(.EVAL_DIV(EVAL_DIV)) u_wide (
    .clk(clk), .rst(rst), .restart_i(arm_i),
    .enable_i(armed_o && mode_q == MODE_WIDE),
    .match_i(win_match), .hit_o(wide_hit)
  );

  assign edge_hit = prev_ok && (prev_q != value_q[0]) && (cur_bit == value_q[0]);

  always_comb begin
    unique case (mode_q)
      MODE_EDGE: fire = armed_o && edge_hit;
      MODE_FAST: fire = armed_o && win_match;
      MODE_WIDE: fire = armed_o && wide_hit;
      default:   fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_EDGE;
      base_q  <= '0;
      width_q <= '0;
      value_q <= '0;
      armed_o <= 1'b0;
      trig_o  <= 1'b0;
      prev_q  <= 1'b0;
      prev_ok <= 1'b0;
    end else if (arm_i) begin
      mode_q  <= trig_mode_e'(cfg_mode);
      base_q  <= cfg_base;
      width_q <= cfg_width;
      value_q <= cfg_value;
      armed_o <= cfg_ok;
      trig_o  <= 1'b0;
      prev_ok <= 1'b0;
    end else begin
      prev_q  <= cur_bit;
      prev_ok <= armed_o;
      if (fire) begin
        trig_o  <= 1'b1;
        armed_o <= 1'b0;
      end
    end
  end

  a_r8_trig_holds: assert property (@(posedge clk) disable iff (rst)
    trig_o && !arm_i |=> trig_o);
  a_r8_arm_clears: assert property (@(posedge clk) disable iff (rst)
    arm_i |=> !trig_o);
  a_r9_idle_after_fire: assert property (@(posedge clk) disable iff (rst)
    $rose(trig_o) |-> !armed_o);
  a_r7_refused: assert property (@(posedge clk) disable iff (rst)
    arm_i && !cfg_ok |=> !armed_o);
  a_r6_wide_latency: assert property (@(posedge clk) disable iff (rst)
    $rose(trig_o) && mode_q == MODE_WIDE |-> $past(wide_hit));
endmodule

// File: tb/pattern_trigger_test.sv
module pattern_trigger_test;
  localparam int CLK_P = 10;
  localparam int NCH = 24;

  logic clk = 0, rst = 1, arm = 0;
  logic [NCH-1:0] chan = '0;
  logic [1:0] mode = 0;
  logic [4:0] base = 0, width = 0;
  logic [15:0] value = 0;
  logic trig, armed;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  pattern_trigger uut (
    .clk(clk), .rst(rst), .chan_i(chan), .cfg_mode(mode), .cfg_base(base),
    .cfg_width(width), .cfg_value(value), .arm_i(arm), .trig_o(trig), .armed_o(armed)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // Arm edge happens inside; returns at the negedge after it.
  task automatic do_arm(input logic [1:0] m, input logic [4:0] b, input logic [4:0] w,
                        input logic [15:0] v);
    mode = m; base = b; width = w; value = v; arm = 1;
    step(1);
    arm = 0;
  endtask

  task automatic t_reset;
    chk("R1 trig", trig, 0);
    chk("R1 armed", armed, 0);
  endtask

  task automatic t_edge_rise;
    chan = '0;
    do_arm(2'd0, 5'd7, 5'd1, 16'h1);
    chk("R9 armed after arm", armed, 1);
    step(2);
    chk("R2 no early fire", trig, 0);
    chan[7] = 1;
    step(1);
    chk("R2 rising fires", trig, 1);
    chk("R9 disarmed after fire", armed, 0);
  endtask

  task automatic t_edge_fall;
    chan = '0;
    do_arm(2'd0, 5'd20, 5'd1, 16'h0);
    step(2);
    chan[20] = 1;
    step(2);
    chk("R3 rising ignored", trig, 0);
    chan[20] = 0;
    step(1);
    chk("R3 falling fires", trig, 1);
  endtask

  task automatic t_fast;
    chan = '1;
    chan[6:4] = 3'b011;
    do_arm(2'd1, 5'd4, 5'd3, 16'b110);
    step(2);
    chk("R4 reversed order no fire", trig, 0);
    chan = 24'h5A5A5A;
    chan[6:4] = 3'b110;
    step(1);
    chk("R10 R4 window match fires", trig, 1);
    chan = '0;
    step(3);
    chk("R8 holds after inputs change", trig, 1);
  endtask

  task automatic t_fast_top;
    chan = '0;
    do_arm(2'd1, 5'd19, 5'd5, 16'h1F);
    chk("R7 top window accepted", armed, 1);
    chan[23:19] = 5'h1F;
    step(1);
    chk("R4 top window fires", trig, 1);
    do_arm(2'd1, 5'd19, 5'd5, 16'h1F);
    chk("R8 arm clears trig", trig, 0);
  endtask

  task automatic t_refuse;
    chan = '1;
    do_arm(2'd1, 5'd0, 5'd6, 16'h3F);
    step(3);
    chk("R7 fast width 6 refused", armed, 0);
    chk("R7 fast width 6 no trig", trig, 0);
    do_arm(2'd2, 5'd10, 5'd8, 16'hFF);
    step(8);
    chk("R7 wide past ch16 refused", {armed, trig}, 0);
    do_arm(2'd3, 5'd0, 5'd1, 16'h1);
    step(8);
    chk("R7 mode 3 refused", {armed, trig}, 0);
    do_arm(2'd1, 5'd0, 5'd0, 16'h0);
    step(3);
    chk("R7 width 0 refused", {armed, trig}, 0);
  endtask

  task automatic t_wide;
    chan = '0;
    do_arm(2'd2, 5'd3, 5'd12, 16'h0A5C);
    step(1);
    chan[14:3] = 12'hA5C;   // present only on edge arm+2, not an eval edge
    step(1);
    chan = '0;
    step(6);
    chk("R5 short match missed", trig, 0);
    chk("R9 still armed", armed, 1);
    chan = 24'hF00000;
    chan[14:3] = 12'hA5C;
    do_arm(2'd2, 5'd3, 5'd12, 16'h0A5C);
    step(2);
    chk("R6 not yet at eval edge", trig, 0);
    step(1);
    chk("R6 still 0 one clock after eval", trig, 0);
    step(1);
    chk("R6 fires two clocks after eval", trig, 1);
  endtask

  task automatic t_wide_full;
    chan = '0;
    chan[15:0] = 16'hBEEF;
    do_arm(2'd2, 5'd0, 5'd16, 16'hBEEF);
    chk("R7 full 16-bit window accepted", armed, 1);
    step(4);
    chk("R5 R6 full window fires", trig, 1);
    chan = '0;
    chan[15:0] = 16'hBEEF;
    chan[16] = 1;
    do_arm(2'd2, 5'd0, 5'd16, 16'hBEEE);
    step(8);
    chk("R5 mismatch no fire", trig, 0);
  endtask

  initial begin
    step(3);
    rst = 0;
    step(1);
    t_reset();
    t_edge_rise();
    t_edge_fall();
    t_fast();
    t_fast_top();
    t_refuse();
    t_wide();
    t_wide_full();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule